// File: doc/BRIEF.md
# Indirect-Access Switch Address Table

This block holds the address table of an Ethernet switch and exposes it to software only through a small 32-bit register window. Each table entry is 68 bits wide. The table is never mapped into the address space directly. Software stages an entry in three 32-bit data words and then writes a table-control register. That register carries the entry index and a direction bit. One direction copies the staged words into the selected slot. The other copies the slot back into the staged words. The word order is reversed: the lowest entry bits sit in the highest-addressed word.

Alongside the window sit three more registers. A fixed identification register gives the version. A status register reports the table size as a code. A global control register holds an enable flag, a table-clear command that sweeps every slot to the free type, and an age-out trigger that is passed out as a one-cycle strobe. A table-control access made during a clear sweep is held off through a ready signal.

Top module: `sw_addr_table`

## Requirements
- R1: A read of offset 0x00 returns the version: major in bits 15:8, minor in bits 7:0, zeros above. The default is 0x0000_0104.
- R2: A read of offset 0x04 returns the table-size code in bits 4:0, with zeros above. Code 0 means 64 entries and code n means n×1024 entries. The default code is 0.
- R3: The data words at offsets 0x34 (word 0), 0x38 (word 1) and 0x3C (word 2) can be written and read back as full 32-bit values.
- R4: A write to offset 0x20 with bit 31 set stores {word0[3:0], word1, word2} into entry bits 67:0 at the index in bits 30:0. A later write with bit 31 clear loads entry bits 31:0 into word 2, bits 63:32 into word 1 and bits 67:64 into word 0.
- R5: After a table load, word 0 bits 31:4 read as zero.
- R6: A table-control index at or above the table size changes no entry on a commit, even when its low bits alias a valid slot. A load of such an index sets all three data words to zero.
- R7: Writing 1 to bit 30 of offset 0x08 clears entry bits 61:60 (the entry type, 0 = free) in every slot and leaves all other entry bits unchanged. Bit 30 reads 1 for exactly table-size cycles and then returns to 0 by itself.
- R8: While a clear sweep runs, a bus access to offset 0x20 sees bus_ready low and takes effect only once the sweep has finished. An access to any other offset is accepted.
- R9: Bit 31 of offset 0x08 is a stored enable flag that reads back as written.
- R10: Writing 1 to bit 29 of offset 0x08 raises age_strobe for exactly the following cycle. The bit reads as 0.
- R11: After reset, offset 0x08 reads 0, the three data words read 0, and bus_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel | input | 1 | Register access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| bus_ready | output | 1 | Low while a table-control access is held off |
| age_strobe | output | 1 | One-cycle age-out trigger pulse |

## Verification
The assertions assume that a requester holds bus_sel, bus_addr and bus_wdata steady until bus_ready is high. They also assume that the table is not read before it has been written or cleared, so no entry holds unknown bits when its contents are compared. The stimulus drives inputs only on falling edges and keeps each access raised until it is accepted. It loads only slots it has committed or cleared, and it starts each clear sweep only when no other sweep is running.

// File: rtl/sw_addr_table.sv
module sw_addr_table #(
  parameter int          ADDR_W    = 8,
  parameter int          DATA_W    = 32,
  parameter int          ENTRY_W   = 68,
  parameter logic [4:0]  SIZE_CODE = 5'd0,
  parameter logic [7:0]  VER_MAJOR = 8'd1,
  parameter logic [7:0]  VER_MINOR = 8'd4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic              age_strobe
);
  localparam int DEPTH  = (SIZE_CODE == 5'd0) ? 64 : int'(SIZE_CODE) * 1024;
  localparam int IDX_W  = $clog2(DEPTH);
  localparam int HI_W   = ENTRY_W - 2 * DATA_W;
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_CTL  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_TCTL = ADDR_W'(8'h20);
  localparam logic [ADDR_W-1:0] A_W0   = ADDR_W'(8'h34);
  localparam logic [ADDR_W-1:0] A_W1   = ADDR_W'(8'h38);
  localparam logic [ADDR_W-1:0] A_W2   = ADDR_W'(8'h3C);

  logic [ENTRY_W-1:0] tbl [DEPTH];
  logic [DATA_W-1:0]  win0, win1, win2;
  logic [DATA_W-2:0]  tidx;
  logic               en_q, clr_run;
  logic [IDX_W-1:0]   clr_idx;

  logic acc, wr_acc, tctl_op, in_rng;
  logic [DATA_W-2:0] req_idx;
  logic [IDX_W-1:0]  slot;

  assign bus_ready = !(clr_run && bus_addr == A_TCTL);
  assign acc       = bus_sel && bus_ready;
  assign wr_acc    = acc && bus_wr;
  assign req_idx   = bus_wdata[DATA_W-2:0];
  assign in_rng    = {1'b0, req_idx} < DATA_W'(DEPTH);
  assign slot      = req_idx[IDX_W-1:0];
  assign tctl_op   = wr_acc && bus_addr == A_TCTL;

  always_ff @(posedge clk) begin
    if (rst) begin
      win0 <= '0; win1 <= '0; win2 <= '0;
      tidx <= '0; en_q <= 1'b0; clr_run <= 1'b0;
      clr_idx <= '0; age_strobe <= 1'b0;
    end else begin
      age_strobe <= wr_acc && bus_addr == A_CTL && bus_wdata[29];
      if (wr_acc && bus_addr == A_W0) win0 <= bus_wdata;
      if (wr_acc && bus_addr == A_W1) win1 <= bus_wdata;
      if (wr_acc && bus_addr == A_W2) win2 <= bus_wdata;
      if (wr_acc && bus_addr == A_CTL) begin
        en_q <= bus_wdata[31];
        if (bus_wdata[30] && !clr_run) begin
          clr_run <= 1'b1;
          clr_idx <= '0;
        end
      end
      if (clr_run) begin
        clr_idx <= clr_idx + 1'b1;
        if (clr_idx == IDX_W'(DEPTH - 1)) clr_run <= 1'b0;
      end
      if (tctl_op) begin
        tidx <= req_idx;
        if (!bus_wdata[31]) begin
          if (in_rng) begin
            win2 <= tbl[slot][DATA_W-1:0];
            win1 <= tbl[slot][2*DATA_W-1:DATA_W];
            win0 <= DATA_W'(tbl[slot][ENTRY_W-1:2*DATA_W]);
          end else begin
            win0 <= '0; win1 <= '0; win2 <= '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst && tctl_op && bus_wdata[31] && in_rng)
      tbl[slot] <= {win0[HI_W-1:0], win1, win2};
    if (!rst && clr_run)
      tbl[clr_idx][61:60] <= 2'b00;
  end

  always_comb begin
    case (bus_addr)
      A_ID:    bus_rdata = {16'h0, VER_MAJOR, VER_MINOR};
      A_STAT:  bus_rdata = {27'h0, SIZE_CODE};
      A_CTL:   bus_rdata = {en_q, clr_run, 30'h0};
      A_TCTL:  bus_rdata = {1'b0, tidx};
      A_W0:    bus_rdata = win0;
      A_W1:    bus_rdata = win1;
      A_W2:    bus_rdata = win2;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module sw_addr_table_chk #(
  parameter int DEPTH = 64,
  parameter int IDX_W = 6
) (
  input logic        clk,
  input logic        rst,
  input logic        bus_sel,
  input logic        bus_wr,
  input logic [7:0]  bus_addr,
  input logic [31:0] bus_wdata,
  input logic        bus_ready,
  input logic        age_strobe,
  input logic        clr_run,
  input logic [31:0] win0,
  input logic [31:0] win1,
  input logic [31:0] win2,
  input logic [67:0] tbl [DEPTH]
);
  int unsigned clr_cnt;
  always_ff @(posedge clk) begin
    if (rst || !clr_run) clr_cnt <= 0;
    else clr_cnt <= clr_cnt + 1;
  end

  // R7
  clr_len_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(clr_run) |-> clr_cnt == DEPTH);

  // R4
  commit_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_ready && bus_wr && bus_addr == 8'h20 && bus_wdata[31] &&
     bus_wdata[30:0] < 31'(DEPTH))
    |=> tbl[$past(bus_wdata[IDX_W-1:0])] == $past({win0[3:0], win1, win2}));

  // R5
  load_hi_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_ready && bus_wr && bus_addr == 8'h20 && !bus_wdata[31])
    |=> win0[31:4] == 28'h0);

  // R8
  stall_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_addr == 8'h20 && clr_run)
    |=> $stable(win0) && $stable(win1) && $stable(win2));

  // R10
  age_src_chk: assert property (@(posedge clk) disable iff (rst)
    age_strobe |-> $past(bus_sel && bus_wr && bus_addr == 8'h08 && bus_wdata[29]));

  // R11
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !clr_run |-> bus_ready);
endmodule

bind sw_addr_table sw_addr_table_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
  .age_strobe(age_strobe), .clr_run(clr_run),
  .win0(win0), .win1(win1), .win2(win2), .tbl(tbl)
);

// File: tb/sw_addr_table_tb.sv
`timescale 1ns/1ps
module sw_addr_table_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_ready, age_strobe;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  sw_addr_table u_dut (.*);

  localparam int NV = 26;
  // {write, addr, data (write data or expected read), requirement number}
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 8'h00, 32'h0000_0104, 4'd1},   // R1
    {1'b0, 8'h04, 32'h0000_0000, 4'd2},   // R2
    {1'b1, 8'h3C, 32'hA1B2_C3D4, 4'd3},   // R3
    {1'b0, 8'h3C, 32'hA1B2_C3D4, 4'd3},
    {1'b1, 8'h38, 32'h3123_5566, 4'd3},
    {1'b0, 8'h38, 32'h3123_5566, 4'd3},
    {1'b1, 8'h34, 32'hFFFF_FFFE, 4'd3},
    {1'b0, 8'h34, 32'hFFFF_FFFE, 4'd3},
    {1'b1, 8'h20, 32'h8000_0005, 4'd4},   // R4 commit slot 5
    {1'b1, 8'h34, 32'h0, 4'd4},
    {1'b1, 8'h38, 32'h0, 4'd4},
    {1'b1, 8'h3C, 32'h0, 4'd4},
    {1'b1, 8'h20, 32'h0000_0005, 4'd4},   // load slot 5
    {1'b0, 8'h3C, 32'hA1B2_C3D4, 4'd4},
    {1'b0, 8'h38, 32'h3123_5566, 4'd4},
    {1'b0, 8'h34, 32'h0000_000E, 4'd5},   // R5
    {1'b1, 8'h20, 32'h0000_0040, 4'd6},   // R6 load index 64
    {1'b0, 8'h3C, 32'h0, 4'd6},
    {1'b0, 8'h34, 32'h0, 4'd6},
    {1'b1, 8'h38, 32'h1111_1111, 4'd6},
    {1'b1, 8'h20, 32'h8000_0045, 4'd6},   // commit index 69 (aliases 5)
    {1'b1, 8'h20, 32'h0000_0005, 4'd6},
    {1'b0, 8'h38, 32'h3123_5566, 4'd6},
    {1'b1, 8'h08, 32'h8000_0000, 4'd9},   // R9
    {1'b0, 8'h08, 32'h8000_0000, 4'd9},
    {1'b0, 8'h00, 32'h0000_0104, 4'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    while (!bus_ready) @(negedge clk);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int cnt;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R11 reset state
    bus_read(8'h08, rd); check("R11 ctl", rd, 32'h0);
    bus_read(8'h34, rd); check("R11 w0", rd, 32'h0);
    bus_read(8'h3C, rd); check("R11 w2", rd, 32'h0);
    check("R11 ready", {31'h0, bus_ready}, 32'h1);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) bus_write(VEC[i][43:36], VEC[i][35:4]);
      else begin
        bus_read(VEC[i][43:36], rd);
        check($sformatf("R%0d vec%0d", VEC[i][3:0], i), rd, VEC[i][35:4]);
      end
    end

    // R10 age-out strobe, enable kept
    bus_write(8'h08, 32'hA000_0000);
    @(negedge clk); check("R10 pulse", {31'h0, age_strobe}, 32'h1);
    @(negedge clk); check("R10 single", {31'h0, age_strobe}, 32'h0);
    bus_read(8'h08, rd); check("R10 readback", rd, 32'h8000_0000);

    // R7 clear sweep length and effect
    bus_write(8'h08, 32'hC000_0000);
    cnt = 0;
    bus_read(8'h08, rd);
    while (rd[30] && cnt < 5000) begin
      cnt++;
      bus_read(8'h08, rd);
    end
    check("R7 sweep cycles", 32'(cnt), 32'd64);
    check("R7 ctl after", rd, 32'h8000_0000);
    bus_write(8'h20, 32'h0000_0005);
    bus_read(8'h38, rd); check("R7 type freed", rd, 32'h0123_5566);
    bus_read(8'h3C, rd); check("R7 low kept", rd, 32'hA1B2_C3D4);
    bus_read(8'h34, rd); check("R7 high kept", rd, 32'h0000_000E);

    // R8 stall of table control during a sweep
    bus_write(8'h08, 32'h4000_0000);
    bus_write(8'h34, 32'h0000_0005);
    bus_write(8'h38, 32'h2222_3333);
    bus_write(8'h3C, 32'h4444_5555);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h20; bus_wdata = 32'h8000_0009;
    #1 check("R8 ready low", {31'h0, bus_ready}, 32'h0);
    while (!bus_ready) @(negedge clk);
    @(posedge clk); #1;
    bus_sel = 1'b0; bus_wr = 1'b0;
    bus_read(8'h08, rd); check("R8 sweep done", rd, 32'h0);
    bus_write(8'h34, 32'h0);
    bus_write(8'h38, 32'h0);
    bus_write(8'h20, 32'h0000_0009);
    bus_read(8'h38, rd); check("R8 commit after sweep", rd, 32'h2222_3333);
    bus_read(8'h34, rd); check("R8 word0", rd, 32'h0000_0005);

    finish_run();
  end
endmodule